// File: doc/BRIEF.md
# ADC-Shared GPIO Port Bank

This block is the port logic for a bank of general-purpose pins whose pads double as analog inputs of a converter. Each pin holds an output data latch and a direction bit, written through a simple masked register interface. A 5-bit channel code from the converter is decoded into a one-hot claim vector. A claimed pin has its output buffer disabled, so it acts as an input to the analog path whatever the port registers hold. Pins that are not claimed behave as ordinary GPIO.

Register writes to a claimed pin are still stored. The stored values take effect once the converter moves to another channel. A port read returns one bit per pin. For a pin whose direction bit is 1 the bit is the latch. For a pin whose direction bit is 0 it is the synchronised pad level. The claim plays no part in this read selection. The lowest channel codes belong to dedicated analog inputs that have no GPIO function, so those codes claim no pin. Codes above the pin range claim nothing either.

The register port is a plain control interface with no valid/ready handshake. A write is accepted on every cycle in which `wr_en` is high, and a read is combinational. Nothing in the block can stall.

Top module: `gpio_adc_port`

## Requirements
- R1: After reset every data latch and every direction bit is 0, so all `pad_oe` bits are 0 and `pad_out` is all zeros.
- R2: `adc_claim[i]` is 1 exactly when `adc_ch` equals BASE_CH+i (BASE_CH=2, N_PINS=11, so codes 2..12). Codes 0 and 1 (dedicated analog inputs) and codes 13..31 claim no pin. At most one claim bit is set.
- R3: `pad_oe[i]` equals direction bit i AND NOT `adc_claim[i]`. A claimed pin is never driven.
- R4: With `wr_en`=1, `wr_sel`=0 selects the data latch and `wr_sel`=1 selects the direction bits. Each bit whose `wr_mask` bit is 1 takes the value of `wr_data` at the clock edge, and this holds for claimed pins too.
- R5: `pad_out[i]` always shows data latch i. A claimed pin's latch keeps its written value, and that value reaches the pad once the claim is released.
- R6: With `rd_sel`=0, a pin whose direction bit is 0 reads back `pad_in` delayed by SYNC_STAGES (2) clock edges. This holds whether or not the pin is claimed.
- R7: With `rd_sel`=0, a pin whose direction bit is 1 reads back its data latch, even while it is claimed.
- R8: With `rd_sel`=1, `rd_data` returns the direction bits.
- R9: Bits whose `wr_mask` bit is 0 do not change. When `wr_en` is 0, neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_ch | input | 5 | Converter channel code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 data latch, 1 direction |
| wr_mask | input | 11 | Per-bit write enable |
| wr_data | input | 11 | Write value |
| rd_sel | input | 1 | Read source: 0 port value, 1 direction |
| rd_data | output | 11 | Read value (combinational) |
| pad_in | input | 11 | Pad input levels (asynchronous) |
| pad_out | output | 11 | Pad output values |
| pad_oe | output | 11 | Pad output enables |
| adc_claim | output | 11 | One-hot pin claim toward the analog multiplexer |

## Verification
The assertions rely on three conditions. `adc_ch`, `wr_*` and `rd_sel` change only away from the clock edge. `adc_ch` is a plain 5-bit code. `pad_in` may change at any time, because the read check is made only after the synchroniser. The stimulus drives every input on the falling edge. It draws channel codes across the whole 0..31 range, so that codes with no pin appear, and it holds a pin claimed while that pin's registers are rewritten. The bench models the two-edge pad delay itself when it computes the expected port reads.

// File: rtl/gpio_adc_pkg.sv
package gpio_adc_pkg;
  localparam int unsigned CH_W = 5;

  typedef enum logic {
    SEL_PORT = 1'b0,
    SEL_DIR  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_adc_claim_dec.sv
module gpio_adc_claim_dec #(
  parameter int unsigned CH_W    = 5,
  parameter int unsigned N_PINS  = 11,
  parameter int unsigned BASE_CH = 2
) (
  input  logic [CH_W-1:0]   ch,
  output logic [N_PINS-1:0] claim
);
  localparam int unsigned LAST_CH = BASE_CH + N_PINS - 1;

  initial begin
    if (LAST_CH >= (1 << CH_W)) $error("pin range exceeds channel code space");
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_dec
    localparam logic [CH_W-1:0] CODE = CH_W'(BASE_CH + i);
    assign claim[i] = (ch == CODE);
  end
endmodule

// File: rtl/gpio_adc_in_sync.sv
module gpio_adc_in_sync #(
  parameter int unsigned N_PINS = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] d,
  output logic [N_PINS-1:0] q
);
  logic [N_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_adc_pin_cell.sv
module gpio_adc_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_we,
  input  logic dir_we,
  input  logic wbit,
  input  logic claim,
  input  logic pin_sync,
  output logic pad_out,
  output logic pad_oe,
  output logic rd_port,
  output logic rd_dir
);
  logic lat_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      if (lat_we) lat_q <= wbit;
      if (dir_we) dir_q <= wbit;
    end
  end

  assign pad_out = lat_q;
  assign pad_oe  = dir_q & ~claim;
  assign rd_port = dir_q ? lat_q : pin_sync;
  assign rd_dir  = dir_q;

  AST_LAT_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |=> (pad_out == $past(wbit)));                          // R4
  AST_DIR_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (rd_dir == $past(wbit)));                           // R4
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_we |=> $stable(pad_out));                                 // R9
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(rd_dir));                                  // R9
endmodule

// File: rtl/gpio_adc_port.sv
module gpio_adc_port #(
  parameter int unsigned N_PINS      = 11,
  parameter int unsigned BASE_CH     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [gpio_adc_pkg::CH_W-1:0]   adc_ch,
  input  logic                            wr_en,
  input  logic                            wr_sel,
  input  logic [N_PINS-1:0]               wr_mask,
  input  logic [N_PINS-1:0]               wr_data,
  input  logic                            rd_sel,
  output logic [N_PINS-1:0]               rd_data,
  input  logic [N_PINS-1:0]               pad_in,
  output logic [N_PINS-1:0]               pad_out,
  output logic [N_PINS-1:0]               pad_oe,
  output logic [N_PINS-1:0]               adc_claim
);
  import gpio_adc_pkg::*;

  logic [N_PINS-1:0] pin_sync, rd_port, rd_dir;
  logic              lat_sel, dir_sel;

  assign lat_sel = wr_en & (reg_sel_e'(wr_sel) == SEL_PORT);
  assign dir_sel = wr_en & (reg_sel_e'(wr_sel) == SEL_DIR);

  gpio_adc_claim_dec #(
    .CH_W(CH_W), .N_PINS(N_PINS), .BASE_CH(BASE_CH)
  ) u_dec (
    .ch(adc_ch), .claim(adc_claim)
  );

  gpio_adc_in_sync #(
    .N_PINS(N_PINS), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_adc_pin_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .lat_we  (lat_sel & wr_mask[i]),
      .dir_we  (dir_sel & wr_mask[i]),
      .wbit    (wr_data[i]),
      .claim   (adc_claim[i]),
      .pin_sync(pin_sync[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i]),
      .rd_port (rd_port[i]),
      .rd_dir  (rd_dir[i])
    );

    AST_CLAIMED_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      adc_claim[i] |-> !pad_oe[i]);                                // R3
    AST_DIR_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel_e'(rd_sel) == SEL_PORT && rd_dir[i]) |-> (rd_data[i] == pad_out[i])); // R7
  end

  assign rd_data = (reg_sel_e'(rd_sel) == SEL_DIR) ? rd_dir : rd_port;

  AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_claim));                                          // R2
  AST_DEDICATED_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ch < BASE_CH) |-> (adc_claim == '0));                     // R2
endmodule

// File: tb/gpio_adc_port_tb.sv
module gpio_adc_port_tb;
  localparam int N = 11;
  localparam int BASE = 2;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] adc_ch = 5'd31;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [N-1:0] wr_mask = '0, wr_data = '0, pad_in = '0;
  logic [N-1:0] rd_data, pad_out, pad_oe, adc_claim;

  int checks = 0, errors = 0;
  logic [N-1:0] m_lat = '0, m_dir = '0;
  logic [N-1:0] m_pipe [SYN];

  always #2.5 clk = ~clk;

  gpio_adc_port u_dut (
    .clk(clk), .rst_n(rst_n), .adc_ch(adc_ch), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_mask(wr_mask), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .adc_claim(adc_claim)
  );

  function automatic logic [N-1:0] exp_claim(logic [4:0] ch);
    logic [N-1:0] c = '0;
    if (int'(ch) >= BASE && int'(ch) < BASE + N) c[int'(ch) - BASE] = 1'b1;
    return c;
  endfunction

  function automatic logic [N-1:0] exp_rd(logic sel);
    if (sel) return m_dir;
    return (m_dir & m_lat) | (~m_dir & m_pipe[SYN-1]);
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 claim", adc_claim, exp_claim(adc_ch));
    chk("R3 oe", pad_oe, m_dir & ~exp_claim(adc_ch));
    chk("R5 pad_out", pad_out, m_lat);
    chk(rd_sel ? "R8 read dir" : "R6/R7 read port", rd_data, exp_rd(rd_sel));
  endtask

  // one cycle: inputs already driven after negedge; check, then advance model at posedge
  task automatic step();
    #1 check_all();
    @(posedge clk);
    if (wr_en) begin
      if (wr_sel) m_dir = (m_dir & ~wr_mask) | (wr_data & wr_mask);
      else        m_lat = (m_lat & ~wr_mask) | (wr_data & wr_mask);
    end
    for (int s = SYN-1; s > 0; s--) m_pipe[s] = m_pipe[s-1];
    m_pipe[0] = pad_in;
    @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [N-1:0] mask, logic [N-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_mask = mask; wr_data = data;
    step();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < SYN; s++) m_pipe[s] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe at reset", pad_oe, '0);
    chk("R1 out at reset", pad_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sel = 1'b1;
    #1 chk("R1 dir at reset", rd_data, '0);

    // R2 dedicated analog codes and out-of-range codes claim nothing
    adc_ch = 5'd0; #1 chk("R2 code0", adc_claim, '0);
    adc_ch = 5'd1; #1 chk("R2 code1", adc_claim, '0);
    adc_ch = 5'd13; #1 chk("R2 code13", adc_claim, '0);
    adc_ch = 5'd2; #1 chk("R2 code2", adc_claim, 11'h001);
    adc_ch = 5'd12; #1 chk("R2 code12", adc_claim, 11'h400);

    // R4/R5: claim pin 3 (code 5), make all outputs, write latch
    adc_ch = 5'd5;
    wr(1'b1, '1, '1);
    wr(1'b0, '1, 11'h5A5);
    chk("R3 claimed pin undriven", pad_oe, 11'h7F7);
    // R7 read of claimed output pin returns latch
    rd_sel = 1'b0; #1 chk("R7 claimed dir1 read", rd_data, 11'h5A5);
    // write claimed pin latch while claimed; stored
    wr(1'b0, 11'h008, 11'h000);
    chk("R4 claimed latch stored", pad_out, 11'h5A5 & ~11'h008);
    // R9 masked-off bits
    wr(1'b0, 11'h000, 11'h7FF);
    chk("R9 mask zero", pad_out, 11'h5A5 & ~11'h008);
    // R6: make pin 3 input, drive pad high, read after two edges
    wr(1'b1, 11'h008, 11'h000);
    pad_in = 11'h008;
    step(); step();
    #1 chk("R6 claimed dir0 read pad", rd_data & 11'h008, 11'h008);
    // release: set dir again, oe should return
    wr(1'b1, 11'h008, 11'h008);
    adc_ch = 5'd31;
    #1 chk("R5 released pin driven", pad_oe, 11'h7FF);

    // random phase
    for (int it = 0; it < 3000; it++) begin
      adc_ch  = 5'($urandom_range(0, 31));
      wr_en   = 1'($urandom);
      wr_sel  = 1'($urandom);
      wr_mask = N'($urandom);
      wr_data = N'($urandom);
      rd_sel  = 1'($urandom);
      if ($urandom_range(0, 3) == 0) pad_in = N'($urandom);
      step();
    end
    wr_en = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule